// File: doc/BRIEF.md
# Thermal Limit Alert Generator

This block watches a stream of signed temperature conversion results and drives a single alert pin. Each result arrives as a parallel 12-bit word together with a one-cycle valid strobe. The block compares the result with a programmable upper and lower limit. It counts how many qualifying results arrive in a row, and changes the alert state only when that run reaches a programmable depth. This filters out single noisy readings.

Two alert behaviours can be selected. In level mode the pin follows a hysteresis state. The state is set by a run at or above the upper limit and cleared by a run at or below the lower limit. In latched mode the pin is held after a qualifying run until a register-read pulse arrives. After that read, the watched condition alternates between upper and lower. A polarity input selects whether the pin is active low or active high.

A small conversion pacer is also part of the block. It marks conversion windows of a fixed length, one after another, starting right after reset. A shutdown request lets the window in progress finish and then stops further windows.

Top module: `thermal_alert`

## Requirements
- R1: Temperatures and limits are 12-bit two's-complement values compared as signed numbers. A result counts as an upper fault when it is greater than or equal to `lim_hi`, and as a lower fault when it is less than or equal to `lim_lo`.
- R2: `cfg_fq` sets the run depth: 2'b00 needs 1 consecutive fault, 2'b01 needs 2, 2'b10 needs 4 and 2'b11 needs 6.
- R3: Only the condition currently watched counts: upper while idle, lower while alerted. A valid result that is not a fault for the watched condition restarts the run at zero.
- R4: With `cfg_mode`=0 (level mode), a full upper run makes the alert active. It stays active until a full lower run makes it inactive.
- R5: With `cfg_mode`=1 (latched mode), a full run of the watched condition sets the latch and swaps the watched condition. While the latch is set, results are ignored. A `rd_pulse` clears the latch.
- R6: When `rd_pulse` and a valid result fall in the same cycle while latched, the latch is cleared and that result is counted against the newly watched condition. If that result completes a run, the latch stays set.
- R7: With `cfg_pol`=0 the pin is low when the alert is active. With `cfg_pol`=1 the pin is high when the alert is active. The pin is registered and reflects the state and polarity at the same clock edge that updates the state.
- R8: A change of `cfg_fq` or `cfg_mode` clears the run counter. A result arriving in that same cycle is discarded.
- R9: Synchronous reset clears the counter, latch and hysteresis state, and drives the pin to the inactive level for the current `cfg_pol` (high for 0, low for 1).
- R10: After reset, `conv_busy` is high and `conv_done` pulses for one cycle every CONV_CYC clock edges, first CONV_CYC edges after the last reset edge.
- R11: When `cfg_shutdown`=1 is seen at the end of a window, `conv_busy` falls and no further `conv_done` pulses occur. Once `cfg_shutdown` returns to 0, a new window starts at the next edge.
- R12: In level mode, `rd_pulse` has no effect on the pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| res_valid | input | 1 | Conversion result strobe |
| res_temp | input | 12 | Signed conversion result |
| lim_hi | input | 12 | Signed upper limit |
| lim_lo | input | 12 | Signed lower limit |
| cfg_mode | input | 1 | 0 level mode, 1 latched mode |
| cfg_pol | input | 1 | 0 active-low pin, 1 active-high pin |
| cfg_fq | input | 2 | Run-depth code |
| cfg_shutdown | input | 1 | Stop after current conversion window |
| rd_pulse | input | 1 | Register-read pulse that clears the latch |
| alert_pin | output | 1 | Registered alert output |
| conv_busy | output | 1 | Conversion window in progress |
| conv_done | output | 1 | One-cycle end-of-window strobe |

## Verification
Two functions can fall in the same cycle: the read pulse that clears the latch, and a valid result that may complete a new run. The bench drives both together while the latch is set. It does this once with a one-deep run, where the latch must stay set and the watched condition must swap again, and once with a deeper run, where the latch must clear. A configuration change arriving together with a run-completing result is provoked the same way. Here the result must be discarded. The behavioural model is compared with the pin on every clock.

// File: rtl/thermal_alert_pkg.sv
package thermal_alert_pkg;
  localparam int QCNT_W = 3;

  typedef enum logic {WATCH_HI = 1'b0, WATCH_LO = 1'b1} phase_t;

  function automatic logic [QCNT_W-1:0] fq_depth(input logic [1:0] code);
    case (code)
      2'b00:   fq_depth = 3'd1;
      2'b01:   fq_depth = 3'd2;
      2'b10:   fq_depth = 3'd4;
      default: fq_depth = 3'd6;
    endcase
  endfunction
endpackage

// File: rtl/ta_limit_cmp.sv
module ta_limit_cmp #(
  parameter int TEMP_W = 12
) (
  input  logic [TEMP_W-1:0] temp,
  input  logic [TEMP_W-1:0] hi,
  input  logic [TEMP_W-1:0] lo,
  output logic              over_hi,
  output logic              under_lo
);
  // R1: signed comparison, equality counts as crossing
  always_comb begin
    over_hi  = $signed(temp) >= $signed(hi);
    under_lo = $signed(temp) <= $signed(lo);
  end
endmodule

// File: rtl/ta_fault_queue.sv
module ta_fault_queue
  import thermal_alert_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       sample,
  input  logic       fault,
  input  logic       clr,
  input  logic [1:0] fq_code,
  output logic       run_done
);
  logic [QCNT_W-1:0] cnt;
  logic [QCNT_W-1:0] cnt_inc;

  always_comb begin
    cnt_inc  = cnt + 1'b1;
    run_done = sample && fault && !clr && (cnt_inc == fq_depth(fq_code));
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (sample) begin
      if (!fault || run_done) cnt <= '0;
      else                    cnt <= cnt_inc;
    end
  end

  // R2
  cnt_below_depth_chk: assert property (@(posedge clk) disable iff (rst)
    !clr |-> (cnt < fq_depth(fq_code)));

  // R3
  run_restart_chk: assert property (@(posedge clk) disable iff (rst)
    (sample && !fault) |=> (cnt == '0));
endmodule

// File: rtl/ta_alert_fsm.sv
module ta_alert_fsm
  import thermal_alert_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic mode,
  input  logic rd,
  input  logic run_done,
  output logic watch_lo,
  output logic count_en,
  output logic act_next
);
  phase_t phase, phase_n;
  logic   latch, latch_n;

  always_comb begin
    count_en = mode ? (!latch || rd) : 1'b1;
    phase_n  = run_done ? phase_t'(~phase) : phase;
    if (!mode)         latch_n = 1'b0;
    else if (run_done) latch_n = 1'b1;
    else if (rd)       latch_n = 1'b0;
    else               latch_n = latch;
    act_next = mode ? latch_n : (phase_n == WATCH_LO);
    watch_lo = (phase == WATCH_LO);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= WATCH_HI;
      latch <= 1'b0;
    end else begin
      phase <= phase_n;
      latch <= latch_n;
    end
  end

  // R5
  read_clears_latch_chk: assert property (@(posedge clk) disable iff (rst)
    (mode && rd && !run_done) |=> !latch);

  // R12
  level_mode_no_latch_chk: assert property (@(posedge clk) disable iff (rst)
    !mode |=> !latch);
endmodule

// File: rtl/ta_conv_pacer.sv
module ta_conv_pacer #(
  parameter int CONV_CYC = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic shutdown,
  output logic busy,
  output logic done
);
  localparam int CW = (CONV_CYC > 1) ? $clog2(CONV_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(CONV_CYC - 1);

  logic [CW-1:0] ccnt;
  logic          at_last;

  always_comb at_last = busy && (ccnt == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      ccnt <= '0;
      busy <= 1'b1;
      done <= 1'b0;
    end else begin
      done <= at_last;
      if (busy) begin
        if (at_last) begin
          ccnt <= '0;
          busy <= !shutdown;
        end else begin
          ccnt <= ccnt + 1'b1;
        end
      end else if (!shutdown) begin
        busy <= 1'b1;
        ccnt <= '0;
      end
    end
  end

  // R10
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R11
  idle_holds_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && shutdown) |=> (!busy && !done));
endmodule

// File: rtl/thermal_alert.sv
module thermal_alert
  import thermal_alert_pkg::*;
#(
  parameter int TEMP_W   = 12,
  parameter int CONV_CYC = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              res_valid,
  input  logic [TEMP_W-1:0] res_temp,
  input  logic [TEMP_W-1:0] lim_hi,
  input  logic [TEMP_W-1:0] lim_lo,
  input  logic              cfg_mode,
  input  logic              cfg_pol,
  input  logic [1:0]        cfg_fq,
  input  logic              cfg_shutdown,
  input  logic              rd_pulse,
  output logic              alert_pin,
  output logic              conv_busy,
  output logic              conv_done
);
  logic       over_hi, under_lo;
  logic       watch_lo, count_en, act_next, run_done;
  logic [1:0] fq_q;
  logic       mode_q;
  logic       cfg_chg;
  logic       fault_sel;

  ta_limit_cmp #(.TEMP_W(TEMP_W)) u_cmp (
    .temp(res_temp), .hi(lim_hi), .lo(lim_lo),
    .over_hi(over_hi), .under_lo(under_lo)
  );

  always_comb begin
    cfg_chg   = (cfg_fq != fq_q) || (cfg_mode != mode_q);
    fault_sel = watch_lo ? under_lo : over_hi;
  end

  ta_fault_queue u_fq (
    .clk(clk), .rst(rst), .sample(res_valid && count_en),
    .fault(fault_sel), .clr(cfg_chg), .fq_code(cfg_fq),
    .run_done(run_done)
  );

  ta_alert_fsm u_fsm (
    .clk(clk), .rst(rst), .mode(cfg_mode), .rd(rd_pulse),
    .run_done(run_done), .watch_lo(watch_lo),
    .count_en(count_en), .act_next(act_next)
  );

  ta_conv_pacer #(.CONV_CYC(CONV_CYC)) u_pacer (
    .clk(clk), .rst(rst), .shutdown(cfg_shutdown),
    .busy(conv_busy), .done(conv_done)
  );

  always_ff @(posedge clk) begin
    fq_q   <= cfg_fq;
    mode_q <= cfg_mode;
    if (rst) alert_pin <= ~cfg_pol;
    else     alert_pin <= cfg_pol ? act_next : ~act_next;
  end

  // R9
  reset_inactive_chk: assert property (@(posedge clk)
    rst |=> (alert_pin == ~$past(cfg_pol)));

  // R8
  cfg_change_no_run_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_chg |-> !run_done);
endmodule

// File: tb/thermal_alert_bench.sv
module thermal_alert_bench;
  localparam int CC = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic res_valid = 1'b0;
  logic signed [11:0] res_temp = '0;
  logic signed [11:0] lim_hi = 12'sd80;
  logic signed [11:0] lim_lo = -12'sd20;
  logic cfg_mode = 1'b0, cfg_pol = 1'b0, cfg_shutdown = 1'b0, rd_pulse = 1'b0;
  logic [1:0] cfg_fq = 2'b00;
  logic alert_pin, conv_busy, conv_done;

  always #4 clk = ~clk;

  thermal_alert #(.TEMP_W(12), .CONV_CYC(CC)) u_thermal_alert (
    .clk(clk), .rst(rst), .res_valid(res_valid), .res_temp(res_temp),
    .lim_hi(lim_hi), .lim_lo(lim_lo), .cfg_mode(cfg_mode), .cfg_pol(cfg_pol),
    .cfg_fq(cfg_fq), .cfg_shutdown(cfg_shutdown), .rd_pulse(rd_pulse),
    .alert_pin(alert_pin), .conv_busy(conv_busy), .conv_done(conv_done)
  );

  int errors = 0, checks = 0, cycles = 0;
  bit finished = 0;
  string cur_req = "R9";

  // behavioural reference
  int m_cnt, m_cc;
  bit m_phase, m_latch, m_pin, m_busy, m_done, m_pmode;
  logic [1:0] m_pfq;

  function automatic int depth_of(logic [1:0] c);
    return (c == 0) ? 1 : (c == 1) ? 2 : (c == 2) ? 4 : 6;
  endfunction

  always @(posedge clk) begin
    bit fault, done, en, act;
    if (rst) begin
      m_cnt = 0; m_phase = 0; m_latch = 0; m_pin = !cfg_pol;
      m_cc = 0; m_busy = 1; m_done = 0;
    end else begin
      done = 0;
      en = cfg_mode ? (!m_latch || rd_pulse) : 1'b1;
      if (cfg_fq != m_pfq || cfg_mode != m_pmode) m_cnt = 0;
      else if (res_valid && en) begin
        fault = m_phase ? (res_temp <= lim_lo) : (res_temp >= lim_hi);
        if (!fault) m_cnt = 0;
        else if (m_cnt + 1 == depth_of(cfg_fq)) begin m_cnt = 0; done = 1; end
        else m_cnt++;
      end
      if (done) m_phase = !m_phase;
      if (!cfg_mode) m_latch = 0;
      else if (done) m_latch = 1;
      else if (rd_pulse) m_latch = 0;
      act = cfg_mode ? m_latch : m_phase;
      m_pin = cfg_pol ? act : !act;
      m_done = m_busy && (m_cc == CC - 1);
      if (m_busy) begin
        if (m_cc == CC - 1) begin m_cc = 0; m_busy = !cfg_shutdown; end
        else m_cc++;
      end else if (!cfg_shutdown) begin m_busy = 1; m_cc = 0; end
    end
    m_pfq = cfg_fq; m_pmode = cfg_mode;
  end

  task automatic chk(string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b t=%0t", cur_req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (!rst) begin
      chk("alert_pin", alert_pin, m_pin);
      chk("conv_busy", conv_busy, m_busy);
      chk("conv_done", conv_done, m_done);
    end
    if (cycles > 100000 && !finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic put(int t);
    @(negedge clk); res_valid = 1; res_temp = 12'(t);
    @(negedge clk); res_valid = 0;
  endtask

  task automatic run(int t, int n);
    for (int i = 0; i < n; i++) put(t);
  endtask

  task automatic read;
    @(negedge clk); rd_pulse = 1;
    @(negedge clk); rd_pulse = 0;
  endtask

  initial begin
    idle(2);
    @(negedge clk); rst = 0;
    // R9: inactive level right after reset with active-low polarity
    chk("reset pin", alert_pin, 1'b1);
    chk("reset busy", conv_busy, 1'b1);
    cur_req = "R10"; idle(2 * CC + 3);
    cur_req = "R1";  put(80); put(0); put(-20);
    put(-100); put(2047);
    put(-2048);
    cur_req = "R4";  put(79); put(100); put(50); put(-19); put(-21);
    cur_req = "R12"; read(); put(90); read(); idle(2);
    cur_req = "R2";
    for (int q = 1; q < 4; q++) begin
      @(negedge clk); cfg_fq = 2'(q);
      run(200, depth_of(2'(q)) - 1); idle(1);
      put(200); run(-50, depth_of(2'(q)));
    end
    cur_req = "R3";
    run(200, 3); put(10); run(200, 3); put(200); run(-50, 6);
    cur_req = "R8";
    @(negedge clk); cfg_fq = 2'b01;
    put(200);
    @(negedge clk); cfg_fq = 2'b00; res_valid = 1; res_temp = 200;
    @(negedge clk); res_valid = 0;
    put(200); put(-50);
    cur_req = "R5";
    @(negedge clk); cfg_mode = 1; cfg_fq = 2'b00;
    put(200); run(-50, 3); read(); put(-50); put(200); read(); put(200);
    cur_req = "R6";
    put(-50); put(200);
    @(negedge clk); rd_pulse = 1; res_valid = 1; res_temp = -50;
    @(negedge clk); rd_pulse = 0; res_valid = 0;
    idle(2);
    @(negedge clk); cfg_fq = 2'b01;
    @(negedge clk); rd_pulse = 1; res_valid = 1; res_temp = 200;
    @(negedge clk); rd_pulse = 0; res_valid = 0;
    put(200); read();
    cur_req = "R7";
    @(negedge clk); cfg_pol = 1;
    run(-50, 2); idle(2); read(); run(200, 2); read();
    @(negedge clk); cfg_mode = 0; idle(1);
    run(200, 2); idle(1); run(-50, 2);
    cur_req = "R11";
    @(negedge clk); cfg_shutdown = 1; idle(3 * CC);
    @(negedge clk); cfg_shutdown = 0; idle(2 * CC + 2);
    cur_req = "R9";
    @(negedge clk); rst = 1; idle(1);
    @(negedge clk); rst = 0;
    chk("reset pin pol1", alert_pin, 1'b0);
    idle(4);
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule